// File: doc/BRIEF.md
# Mode-Decoding Serial/Parallel Command Port

This block is the digital front end of a multi-channel hold unit. A host talks to it either over a four-wire serial link (frame sync, serial clock, data in, data out) or over a small parallel port (chip select, write strobe, six address lines, calibrate and offset-select lines). A static select input chooses which of the two ports is live. The frame-sync pin also serves as the parallel chip select. All pins are brought through synchronisers into a faster system clock. Edges are found by comparing samples.

A serial word opens with a two-bit operating mode. The mode decides what the block hands to the acquisition sequencer. It can request an acquisition, write a register directly with a 14-bit value, request an acquisition and arm a readback, or arm a readback with no acquisition. The frame length depends on the mode: 10 bits for a header-only word and 24 bits for a direct write. A frame of any other length is dropped and flagged. Once a readback is armed, the next frame shifts the selected 14-bit register out on data-out. That read frame may carry a new command at the same time.

Top module: `modecmd_if`

## Requirements
- R1: Mode field 00 raises `acq_stb` for one cycle. Mode 01 raises `dwr_stb`. Mode 10 raises `acq_stb` and arms a readback. Mode 11 arms a readback and raises no strobe.
- R2: A header word is sent MSB first as mode[1], mode[0], calibrate, offset-select, then address bits 5 down to 0. These fields appear on `cmd_mode`-free outputs `cmd_cal`, `cmd_ofs` and `cmd_addr` in the cycle their strobe is high.
- R3: In mode 01 the frame is 24 bits: the 10-bit header followed by a 14-bit value, bit 13 first. That value appears on `cmd_data` with `dwr_stb`. `cmd_data` changes at no other time.
- R4: `sdo_oe` is high only during a read frame, which runs from the frame-sync falling edge to its rising edge. It is low during every other frame and between frames.
- R5: In the frame after an arming frame, `rd_word` is captured at the frame-sync fall. It is driven out 14 bits MSB first: bit 13 is on `sdo` from the start of the frame, and each serial-clock rising edge moves on to the next bit. `rd_addr`/`rd_ofs` carry the armed channel.
- R6: When frame sync rises, the frame is accepted only if it had exactly 10 serial-clock falls with a mode other than 01, or exactly 24 falls with mode 01. Any other frame gives a one-cycle `frame_err` and no strobe. The exception is a read frame, which is dropped without `frame_err`.
- R7: With `sel_serial` low, serial frames produce no strobe, no error and no `sdo_oe`. With `sel_serial` high, parallel write strobes produce nothing.
- R8: In parallel mode, a rising edge of `wr_n` while `fsync_n` is low raises `acq_stb` with `p_cal`, `p_ofs` and `p_addr` on the command outputs. A `wr_n` rising edge while `fsync_n` is high is ignored.
- R9: `sdi` is sampled only on serial-clock falling edges while frame sync is low. Serial-clock activity while frame sync is high leaves the next frame's decode unchanged.
- R10: After reset no strobe is high, `sdo_oe` is low and no readback is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_serial | input | 1 | Static port select: 1 = serial, 0 = parallel |
| fsync_n | input | 1 | Serial frame sync, and parallel chip select (active low) |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Output enable for `sdo` |
| wr_n | input | 1 | Parallel write strobe, active low |
| p_addr | input | 6 | Parallel channel address |
| p_cal | input | 1 | Parallel calibrate (all-channel) request |
| p_ofs | input | 1 | Parallel offset-channel select |
| acq_stb | output | 1 | Acquisition request pulse |
| dwr_stb | output | 1 | Direct register write pulse |
| frame_err | output | 1 | Malformed serial frame pulse |
| cmd_cal | output | 1 | Calibrate field of the current command |
| cmd_ofs | output | 1 | Offset-select field of the current command |
| cmd_addr | output | 6 | Channel address of the current command |
| cmd_data | output | 14 | Direct-write value |
| rd_addr | output | 6 | Channel address for readback |
| rd_ofs | output | 1 | Readback targets the offset channel |
| rd_word | input | 14 | Register contents for `rd_addr`/`rd_ofs` |

## Verification
The hardest case is a read frame that carries a command at the same time. The readback shift runs on serial-clock rising edges, while the decoder counts falling edges of the same frame. The length check must then stay silent when the count is wrong, and still decode when the count is right. The stimulus reaches this case by arming with a readback-only header. It then sends one 14-clock read frame, which must be dropped with no error. It also sends a 24-clock read frame that carries a direct write, which must produce the readback bits and a `dwr_stb` from the same frame.

// File: rtl/cmdif_pkg.sv
package cmdif_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 14;

  typedef enum logic [1:0] {
    MD_ACQ   = 2'b00,
    MD_DWR   = 2'b01,
    MD_ACQRD = 2'b10,
    MD_RD    = 2'b11
  } op_mode_e;
endpackage

// File: rtl/cmdif_sync.sv
module cmdif_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cmdif_ser_rx.sv
module cmdif_ser_rx
  import cmdif_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fs_fall,
  input  logic          fs_rise,
  input  logic          sc_fall,
  input  logic          sd,
  input  logic          rd_frame,
  output logic          acq_stb,
  output logic          dwr_stb,
  output logic          err_stb,
  output logic          arm_stb,
  output logic          f_cal,
  output logic          f_ofs,
  output logic [AW-1:0] f_addr,
  output logic [DW-1:0] f_data
);
  localparam int HW = 4 + AW;
  localparam int FW = HW + DW;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_HDR = CW'(HW);
  localparam logic [CW-1:0] CNT_FULL = CW'(FW);

  logic [FW-1:0] sh, sh_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          inf, inf_n;
  logic          acq_n, dwr_n, err_n, arm_n;
  logic          cal_n, ofs_n;
  logic [AW-1:0] addr_n;
  logic [DW-1:0] data_n;

  logic          is_short, is_long, ok;
  logic [HW-1:0] hdr;
  op_mode_e      md;

  always_comb begin
    is_short = (cnt == CNT_HDR);
    is_long  = (cnt == CNT_FULL);
    hdr      = is_long ? sh[FW-1:DW] : sh[HW-1:0];
    md       = op_mode_e'(hdr[HW-1 -: 2]);
    ok       = (is_short && md != MD_DWR) || (is_long && md == MD_DWR);
  end

  always_comb begin
    sh_n   = sh;
    cnt_n  = cnt;
    inf_n  = inf;
    acq_n  = 1'b0;
    dwr_n  = 1'b0;
    err_n  = 1'b0;
    arm_n  = 1'b0;
    cal_n  = f_cal;
    ofs_n  = f_ofs;
    addr_n = f_addr;
    data_n = f_data;
    if (!en) begin
      inf_n = 1'b0;
    end else if (fs_fall) begin
      inf_n = 1'b1;
      cnt_n = '0;
      sh_n  = '0;
    end else if (inf && fs_rise) begin
      inf_n = 1'b0;
      if (ok) begin
        cal_n  = hdr[HW-3];
        ofs_n  = hdr[HW-4];
        addr_n = hdr[AW-1:0];
        if (is_long) data_n = sh[DW-1:0];
        unique case (md)
          MD_ACQ:   acq_n = 1'b1;
          MD_DWR:   dwr_n = 1'b1;
          MD_ACQRD: begin acq_n = 1'b1; arm_n = 1'b1; end
          MD_RD:    arm_n = 1'b1;
        endcase
      end else if (!rd_frame) begin
        err_n = 1'b1;
      end
    end else if (inf && sc_fall) begin
      sh_n = {sh[FW-2:0], sd};
      if (cnt != CNT_MAX) cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      inf     <= 1'b0;
      acq_stb <= 1'b0;
      dwr_stb <= 1'b0;
      err_stb <= 1'b0;
      arm_stb <= 1'b0;
      f_cal   <= 1'b0;
      f_ofs   <= 1'b0;
      f_addr  <= '0;
      f_data  <= '0;
    end else begin
      sh      <= sh_n;
      cnt     <= cnt_n;
      inf     <= inf_n;
      acq_stb <= acq_n;
      dwr_stb <= dwr_n;
      err_stb <= err_n;
      arm_stb <= arm_n;
      f_cal   <= cal_n;
      f_ofs   <= ofs_n;
      f_addr  <= addr_n;
      f_data  <= data_n;
    end
  end
endmodule

// File: rtl/cmdif_ser_tx.sv
module cmdif_ser_tx
  import cmdif_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fs_fall,
  input  logic          fs_rise,
  input  logic          sc_rise,
  input  logic          arm,
  input  logic [DW-1:0] word,
  output logic          active,
  output logic          sdo
);
  logic [DW-1:0] sh, sh_n;
  logic          pend, pend_n, act_n;

  always_comb begin
    sh_n   = sh;
    pend_n = pend;
    act_n  = active;
    if (!en) begin
      pend_n = 1'b0;
      act_n  = 1'b0;
    end else begin
      if (fs_fall && pend) begin
        act_n  = 1'b1;
        pend_n = 1'b0;
        sh_n   = word;
      end else if (fs_rise) begin
        act_n = 1'b0;
      end else if (active && sc_rise) begin
        sh_n = {sh[DW-2:0], 1'b0};
      end
      if (arm) pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      pend   <= 1'b0;
      active <= 1'b0;
    end else begin
      sh     <= sh_n;
      pend   <= pend_n;
      active <= act_n;
    end
  end

  assign sdo = sh[DW-1];
endmodule

// File: rtl/cmdif_par.sv
module cmdif_par
  import cmdif_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs_low,
  input  logic          wr_rise,
  input  logic          cal_in,
  input  logic          ofs_in,
  input  logic [AW-1:0] addr_in,
  output logic          acq_stb,
  output logic          f_cal,
  output logic          f_ofs,
  output logic [AW-1:0] f_addr
);
  logic          take;
  logic          cal_n, ofs_n;
  logic [AW-1:0] addr_n;

  always_comb begin
    take   = en && cs_low && wr_rise;
    cal_n  = take ? cal_in  : f_cal;
    ofs_n  = take ? ofs_in  : f_ofs;
    addr_n = take ? addr_in : f_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_stb <= 1'b0;
      f_cal   <= 1'b0;
      f_ofs   <= 1'b0;
      f_addr  <= '0;
    end else begin
      acq_stb <= take;
      f_cal   <= cal_n;
      f_ofs   <= ofs_n;
      f_addr  <= addr_n;
    end
  end
endmodule

// File: rtl/modecmd_if.sv
module modecmd_if
  import cmdif_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_serial,
  input  logic          fsync_n,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic          wr_n,
  input  logic [AW-1:0] p_addr,
  input  logic          p_cal,
  input  logic          p_ofs,
  output logic          acq_stb,
  output logic          dwr_stb,
  output logic          frame_err,
  output logic          cmd_cal,
  output logic          cmd_ofs,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic [AW-1:0] rd_addr,
  output logic          rd_ofs,
  input  logic [DW-1:0] rd_word
);
  localparam int BW = 7 + AW;
  localparam logic [BW-1:0] IDLE = {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, {AW{1'b0}}};

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic [BW-1:0] raw, syn;
  assign raw = {sel_serial, fsync_n, sclk, sdi, wr_n, p_cal, p_ofs, p_addr};

  cmdif_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_i), .d(raw), .q(syn)
  );

  logic          sel_s, fs_s, sc_s, sd_s, wr_s, cal_s, ofs_s;
  logic [AW-1:0] addr_s;
  assign {sel_s, fs_s, sc_s, sd_s, wr_s, cal_s, ofs_s, addr_s} = syn;

  logic fs_q, sc_q, wr_q;
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      fs_q <= 1'b1;
      sc_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      fs_q <= fs_s;
      sc_q <= sc_s;
      wr_q <= wr_s;
    end
  end

  logic fs_fall, fs_rise, sc_fall, sc_rise, wr_rise;
  always_comb begin
    fs_fall = fs_q & ~fs_s;
    fs_rise = ~fs_q & fs_s;
    sc_fall = sc_q & ~sc_s;
    sc_rise = ~sc_q & sc_s;
    wr_rise = ~wr_q & wr_s;
  end

  logic          s_acq, s_arm, tx_act;
  logic          s_cal, s_ofs;
  logic [AW-1:0] s_addr;

  cmdif_ser_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_i), .en(sel_s),
    .fs_fall(fs_fall), .fs_rise(fs_rise), .sc_fall(sc_fall), .sd(sd_s),
    .rd_frame(tx_act),
    .acq_stb(s_acq), .dwr_stb(dwr_stb), .err_stb(frame_err), .arm_stb(s_arm),
    .f_cal(s_cal), .f_ofs(s_ofs), .f_addr(s_addr), .f_data(cmd_data)
  );

  cmdif_ser_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_i), .en(sel_s),
    .fs_fall(fs_fall), .fs_rise(fs_rise), .sc_rise(sc_rise),
    .arm(s_arm), .word(rd_word), .active(tx_act), .sdo(sdo)
  );

  logic          p_acq, pc_cal, pc_ofs;
  logic [AW-1:0] pc_addr;

  cmdif_par #(.AW(AW)) u_par (
    .clk(clk), .rst_n(rst_i), .en(~sel_s), .cs_low(~fs_s), .wr_rise(wr_rise),
    .cal_in(cal_s), .ofs_in(ofs_s), .addr_in(addr_s),
    .acq_stb(p_acq), .f_cal(pc_cal), .f_ofs(pc_ofs), .f_addr(pc_addr)
  );

  always_comb begin
    acq_stb  = s_acq | p_acq;
    cmd_cal  = sel_s ? s_cal  : pc_cal;
    cmd_ofs  = sel_s ? s_ofs  : pc_ofs;
    cmd_addr = sel_s ? s_addr : pc_addr;
    rd_addr  = s_addr;
    rd_ofs   = s_ofs;
    sdo_oe   = tx_act;
  end
endmodule

// File: rtl/modecmd_if_chk.sv
module modecmd_if_chk
  import cmdif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sel_serial,
  input logic              acq_stb,
  input logic              dwr_stb,
  input logic              frame_err,
  input logic              sdo_oe,
  input logic [DATA_W-1:0] cmd_data
);
  // R1
  excl_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acq_stb, dwr_stb, frame_err}));

  // R7
  dwr_serial_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dwr_stb |-> sel_serial);

  // R4
  oe_serial_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> sel_serial);

  // R6
  no_err_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !$past(sdo_oe));

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dwr_stb |-> $stable(cmd_data));
endmodule

bind modecmd_if modecmd_if_chk u_chk (.*);

// File: tb/sim_modecmd_if.sv
module sim_modecmd_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_serial = 1'b1, fsync_n = 1'b1, sclk = 1'b1, sdi = 1'b0, wr_n = 1'b1;
  logic [5:0] p_addr = '0;
  logic p_cal = 1'b0, p_ofs = 1'b0;
  logic sdo, sdo_oe, acq_stb, dwr_stb, frame_err, cmd_cal, cmd_ofs, rd_ofs;
  logic [5:0] cmd_addr, rd_addr;
  logic [13:0] cmd_data, rd_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  modecmd_if u0 (.*);

  int tests = 0, fails = 0;

  // environment: register file written by the sequencer model
  logic [13:0] regs [64];
  logic [13:0] ofs_reg = '0;
  logic [13:0] vin_code = '0;
  initial for (int i = 0; i < 64; i++) regs[i] = '0;
  assign rd_word = rd_ofs ? ofs_reg : regs[rd_addr];
  always @(posedge clk) begin
    if (dwr_stb) begin
      if (cmd_ofs) ofs_reg <= cmd_data; else regs[cmd_addr] <= cmd_data;
    end
    if (acq_stb) begin
      if (cmd_cal) for (int i = 0; i < 64; i++) regs[i] <= vin_code;
      else if (cmd_ofs) ofs_reg <= vin_code;
      else regs[cmd_addr] <= vin_code;
    end
  end

  // scoreboard
  typedef struct {
    int kind;            // 0 acquire, 1 direct write, 2 framing error
    logic cal, ofs;
    logic [5:0] addr;
    logic [13:0] data;
    string req;
  } exp_t;
  exp_t q[$];
  bit mon_on = 0;

  task automatic expect_evt(int kind, logic cal, logic ofs, logic [5:0] addr,
                            logic [13:0] data, string req);
    exp_t e;
    e.kind = kind; e.cal = cal; e.ofs = ofs; e.addr = addr; e.data = data; e.req = req;
    q.push_back(e);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && (acq_stb || dwr_stb || frame_err)) begin
      int k;
      k = frame_err ? 2 : (dwr_stb ? 1 : 0);
      if (q.size() == 0) begin
        check(0, "R1", "unexpected strobe kind", k, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(k == e.kind, e.req, "strobe kind", k, e.kind);
        if (k == e.kind && k != 2)
          check({cmd_cal, cmd_ofs, cmd_addr} == {e.cal, e.ofs, e.addr}, e.req,
                "cal/ofs/addr", {cmd_cal, cmd_ofs, cmd_addr}, {e.cal, e.ofs, e.addr});
        if (k == e.kind && k == 1)
          check(cmd_data == e.data, e.req, "data", cmd_data, e.data);
      end
    end
  end

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [9:0] hdr(logic [1:0] m, logic c, logic o, logic [5:0] a);
    return {m, c, o, a};
  endfunction

  // nclk serial clocks; word bits sent MSB first from bit nbits-1
  task automatic frame(int nclk, int nbits, logic [23:0] word, bit rd,
                       logic [13:0] exp_rd, string req);
    logic [13:0] got;
    got = '0;
    fsync_n = 1'b0;
    waitc(HALF);
    check(sdo_oe == rd, rd ? "R5" : "R4", "sdo_oe in frame", sdo_oe, rd);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < nbits) ? word[nbits-1-i] : 1'b0;
      if (i < 14) got[13-i] = sdo;
      sclk = 1'b0; waitc(HALF);
      sclk = 1'b1; waitc(HALF);
    end
    if (rd) check(got == exp_rd, req, "readback word", got, exp_rd);
    fsync_n = 1'b1;
    waitc(HALF);
    check(sdo_oe == 1'b0, "R4", "sdo_oe after frame", sdo_oe, 0);
    waitc(HALF);
  endtask

  task automatic par_write(logic c, logic o, logic [5:0] a, logic cs);
    fsync_n = ~cs; waitc(4);
    p_cal = c; p_ofs = o; p_addr = a; waitc(2);
    wr_n = 1'b0; waitc(6);
    wr_n = 1'b1; waitc(6);
    fsync_n = 1'b1; waitc(6);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "WD", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    waitc(5);
    // R10 reset state
    check({acq_stb, dwr_stb, frame_err, sdo_oe} == 4'b0, "R10", "outputs in reset",
          {acq_stb, dwr_stb, frame_err, sdo_oe}, 0);
    rst_n = 1'b1;
    waitc(10);
    check({acq_stb, dwr_stb, frame_err, sdo_oe} == 4'b0, "R10", "outputs after reset",
          {acq_stb, dwr_stb, frame_err, sdo_oe}, 0);
    mon_on = 1;

    // R1 R2: acquire, no readback armed after reset (R10)
    vin_code = 14'h1234;
    expect_evt(0, 0, 0, 6'h05, 0, "R2");
    frame(10, 10, {14'h0, hdr(2'b00, 0, 0, 6'h05)}, 0, 0, "R2");
    // R3 direct writes
    expect_evt(1, 0, 0, 6'h2A, 14'h2ABC, "R3");
    frame(24, 24, {hdr(2'b01, 0, 0, 6'h2A), 14'h2ABC}, 0, 0, "R3");
    expect_evt(1, 0, 1, 6'h00, 14'h0155, "R3");
    frame(24, 24, {hdr(2'b01, 0, 1, 6'h00), 14'h0155}, 0, 0, "R3");
    // R1 readback only: no strobe; R5 short read frame dropped silently (R6)
    frame(10, 10, {14'h0, hdr(2'b11, 0, 0, 6'h2A)}, 0, 0, "R1");
    frame(14, 0, 24'h0, 1, 14'h2ABC, "R5");
    // read offset channel during a frame carrying a direct write
    frame(10, 10, {14'h0, hdr(2'b11, 0, 1, 6'h00)}, 0, 0, "R1");
    expect_evt(1, 0, 0, 6'h07, 14'h0777, "R6");
    frame(24, 24, {hdr(2'b01, 0, 0, 6'h07), 14'h0777}, 1, 14'h0155, "R5");
    // R1 acquire then readback
    vin_code = 14'h0ABC;
    expect_evt(0, 0, 0, 6'h09, 0, "R1");
    frame(10, 10, {14'h0, hdr(2'b10, 0, 0, 6'h09)}, 0, 0, "R1");
    frame(14, 0, 24'h0, 1, 14'h0ABC, "R5");
    // R2 calibrate bit
    vin_code = 14'h0321;
    expect_evt(0, 1, 0, 6'h03, 0, "R2");
    frame(10, 10, {14'h0, hdr(2'b00, 1, 0, 6'h03)}, 0, 0, "R2");
    // R6 framing errors
    expect_evt(2, 0, 0, 0, 0, "R6");
    frame(10, 10, {14'h0, hdr(2'b01, 0, 0, 6'h01)}, 0, 0, "R6");
    expect_evt(2, 0, 0, 0, 0, "R6");
    frame(24, 24, {hdr(2'b00, 0, 0, 6'h01), 14'h3FFF}, 0, 0, "R6");
    expect_evt(2, 0, 0, 0, 0, "R6");
    frame(7, 7, 24'h7F, 0, 0, "R6");
    expect_evt(2, 0, 0, 0, 0, "R6");
    frame(0, 0, 24'h0, 0, 0, "R6");
    // R9 clock activity outside a frame
    for (int i = 0; i < 5; i++) begin
      sdi = i[0]; sclk = 1'b0; waitc(HALF); sclk = 1'b1; waitc(HALF);
    end
    expect_evt(0, 0, 1, 6'h11, 0, "R9");
    frame(10, 10, {14'h0, hdr(2'b00, 0, 1, 6'h11)}, 0, 0, "R9");
    // R8 parallel port
    sel_serial = 1'b0; waitc(10);
    expect_evt(0, 0, 1, 6'h15, 0, "R8");
    par_write(0, 1, 6'h15, 1);
    expect_evt(0, 1, 0, 6'h3F, 0, "R8");
    par_write(1, 0, 6'h3F, 1);
    par_write(0, 0, 6'h22, 0);   // chip select high: ignored (R8)
    // R7 serial frames ignored in parallel mode
    frame(10, 10, {14'h0, hdr(2'b00, 0, 0, 6'h01)}, 0, 0, "R7");
    frame(10, 10, {14'h0, hdr(2'b11, 0, 0, 6'h01)}, 0, 0, "R7");
    frame(14, 0, 24'h0, 0, 0, "R7");
    // R7 write strobes ignored in serial mode
    sel_serial = 1'b1; waitc(10);
    par_write(0, 0, 6'h2B, 0);
    expect_evt(0, 0, 0, 6'h00, 0, "R7");
    frame(10, 10, {14'h0, hdr(2'b00, 0, 0, 6'h00)}, 0, 0, "R7");
    waitc(40);
    check(q.size() == 0, "R1", "missing strobes", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule